// File: doc/BRIEF.md
# Time-of-Day Alarm and Interrupt Request

This block belongs next to a seconds/minutes/hours counter. In every cycle where the counter asserts its once-per-second update strobe, the block compares the new time bytes with three alarm bytes. Each alarm byte acts as a wildcard when its two top bits are both set. A wildcard byte matches every value of its field. With wildcards, a single comparator can fire once a day, once an hour, once a minute or once a second.

The block holds three event flags: time alarm, periodic tick and update ended. It gates each flag with its own enable bit and merges the results into one active-low open-drain interrupt request. The request is a drive-low enable and never drives the line high. It stays active until software reads the flag register. That read returns the flags with a summary bit and clears them. An event that arrives in the same cycle as the read is kept.

Top module: `tod_alarm_irq`

## Requirements
- R1: The time comparison is evaluated only in a cycle where `upd_stb_i` is high. The alarm flag appears in `flags_o` on the cycle after that strobe. Matching time bytes without a strobe leave the alarm flag unchanged.
- R2: An alarm byte whose bits 7 and 6 are both 1 (0xC0 to 0xFF) matches any value of its time byte. Bytes with only one of those bits set, such as 0x80, 0x40 or 0xBF, must match exactly.
- R3: A wildcard in the hours byte alone fires every hour when minutes and seconds match. A wildcard in hours and minutes fires every minute when seconds match. Wildcards in all three bytes fire on every strobe.
- R4: With no wildcard, the alarm flag is set only when hours, minutes and seconds all equal their alarm bytes. The hours byte is compared as a raw byte, so a 12-hour PM code such as 0x92 works.
- R5: Every `upd_stb_i` pulse sets the update-ended flag. Every `per_tick_i` pulse sets the periodic flag. Both flags appear on the following cycle.
- R6: The `flags_o` layout is fixed: bit 7 is the interrupt summary, bit 6 is periodic, bit 5 is alarm, bit 4 is update-ended, and bits 3:0 read as 0.
- R7: Flags are set whatever their enables are. `irq_drive_low_o` and summary bit 7 are high exactly when at least one flag is set together with its enable (`en_per_i`, `en_alm_i`, `en_upd_i`).
- R8: The interrupt is level-held and stays active on every cycle until a read. A cycle with `flag_rd_i` high clears all flags by the next cycle, which releases the request.
- R9: An event arriving in the same cycle as `flag_rd_i` is still set after the clear.
- R10: After reset, all flags are 0 and `irq_drive_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hr_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| upd_stb_i | input | 1 | One-cycle strobe after each time advance |
| per_tick_i | input | 1 | One-cycle periodic tick |
| en_per_i | input | 1 | Periodic interrupt enable |
| en_alm_i | input | 1 | Alarm interrupt enable |
| en_upd_i | input | 1 | Update-ended interrupt enable |
| flag_rd_i | input | 1 | Flag register read strobe (clears flags) |
| flags_o | output | 8 | Flag register value |
| irq_drive_low_o | output | 1 | Pull the open-drain interrupt line low |

## Verification
Any corruption of a flag bit reaches the ports at once, because `flags_o` and `irq_drive_low_o` are decoded combinationally from the flag state. A wrong comparator or a faulty wildcard decode shows up in the alarm bit on the cycle after the strobe. A flag that was not cleared shows up in the cycle after a read. An event lost during a read shows up as a 0 where a 1 is expected in that same cycle. A stuck-on flag keeps the interrupt driven with no event present. The bench catches this immediately after a read that should release it.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
   localparam int TOD_W      = 8;
   localparam int TOD_FIELDS = 3;
   localparam int FLD_SEC    = 0;
   localparam int FLD_MIN    = 1;
   localparam int FLD_HR     = 2;
   // event index inside the flag vector
   localparam int EV_UPD     = 0;
   localparam int EV_ALM     = 1;
   localparam int EV_PER     = 2;
   localparam int EV_N       = 3;
   // bit positions in the readable flag byte
   localparam int BIT_IRQ    = 7;
   localparam int BIT_LOW_EV = 4;
   typedef logic [TOD_W-1:0] tod_byte_t;
   typedef logic [EV_N-1:0]  ev_vec_t;
endpackage

// File: rtl/tod_field_match.sv
module tod_field_match #(
   parameter int W        = 8,
   parameter int WILD_BITS = 2,
   parameter bit WILD_EN  = 1'b1
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] alm_i,
   output logic         hit_o
);
   localparam int TOP = W - 1;

   generate
      if (WILD_EN) begin : g_wild
         logic is_wild;
         assign is_wild = &alm_i[TOP -: WILD_BITS];
         assign hit_o   = is_wild | (cur_i == alm_i);
      end else begin : g_exact
         assign hit_o = (cur_i == alm_i);
      end
   endgenerate
endmodule

// File: rtl/tod_flag_reg.sv
module tod_flag_reg #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] en_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o,
   output logic         irq_o
);
   logic [N-1:0] flag_q;
   logic [N-1:0] flag_d;

   always_comb begin
      flag_d = (clr_i ? '0 : flag_q) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;
   assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
   import tod_alarm_pkg::*;
#(
   parameter int WILD_BITS = 2,
   parameter bit WILD_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] sec_i,
   input  logic [7:0] min_i,
   input  logic [7:0] hr_i,
   input  logic [7:0] alm_sec_i,
   input  logic [7:0] alm_min_i,
   input  logic [7:0] alm_hr_i,
   input  logic       upd_stb_i,
   input  logic       per_tick_i,
   input  logic       en_per_i,
   input  logic       en_alm_i,
   input  logic       en_upd_i,
   input  logic       flag_rd_i,
   output logic [7:0] flags_o,
   output logic       irq_drive_low_o
);
   localparam int PAD_W = BIT_LOW_EV;

   generate
      if (WILD_BITS < 1 || WILD_BITS > TOD_W) begin : g_bad_wild
         $error("WILD_BITS must lie in 1..TOD_W");
      end
      if (BIT_LOW_EV + EV_N != BIT_IRQ) begin : g_bad_layout
         $error("flag layout inconsistent");
      end
   endgenerate

   tod_byte_t cur   [TOD_FIELDS];
   tod_byte_t alm   [TOD_FIELDS];
   logic [TOD_FIELDS-1:0] hit;

   assign cur[FLD_SEC] = sec_i;
   assign cur[FLD_MIN] = min_i;
   assign cur[FLD_HR]  = hr_i;
   assign alm[FLD_SEC] = alm_sec_i;
   assign alm[FLD_MIN] = alm_min_i;
   assign alm[FLD_HR]  = alm_hr_i;

   genvar gi;
   generate
      for (gi = 0; gi < TOD_FIELDS; gi++) begin : g_fld
         tod_field_match #(
            .W(TOD_W), .WILD_BITS(WILD_BITS), .WILD_EN(WILD_EN)
         ) u_match (
            .cur_i(cur[gi]),
            .alm_i(alm[gi]),
            .hit_o(hit[gi])
         );
      end
   endgenerate

   ev_vec_t ev_set;
   ev_vec_t ev_en;
   ev_vec_t ev_flag;
   logic    irq_any;

   always_comb begin
      ev_set         = '0;
      ev_set[EV_UPD] = upd_stb_i;
      ev_set[EV_ALM] = upd_stb_i & (&hit);
      ev_set[EV_PER] = per_tick_i;
      ev_en          = '0;
      ev_en[EV_UPD]  = en_upd_i;
      ev_en[EV_ALM]  = en_alm_i;
      ev_en[EV_PER]  = en_per_i;
   end

   tod_flag_reg #(.N(EV_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set),
      .en_i  (ev_en),
      .clr_i (flag_rd_i),
      .flag_o(ev_flag),
      .irq_o (irq_any)
   );

   assign flags_o         = {irq_any, ev_flag[EV_PER], ev_flag[EV_ALM], ev_flag[EV_UPD], {PAD_W{1'b0}}};
   assign irq_drive_low_o = irq_any;
endmodule

// File: rtl/tod_alarm_irq_chk.sv
module tod_alarm_irq_chk (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] sec_i,
   input  logic [7:0] min_i,
   input  logic [7:0] hr_i,
   input  logic [7:0] alm_sec_i,
   input  logic [7:0] alm_min_i,
   input  logic [7:0] alm_hr_i,
   input  logic       upd_stb_i,
   input  logic       per_tick_i,
   input  logic       en_per_i,
   input  logic       en_alm_i,
   input  logic       en_upd_i,
   input  logic       flag_rd_i,
   input  logic [7:0] flags_o,
   input  logic       irq_drive_low_o
);
   assert_alarm_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_stb_i && !flag_rd_i) |=> $stable(flags_o[5]));

   assert_all_wild_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb_i && (&alm_hr_i[7:6]) && (&alm_min_i[7:6]) && (&alm_sec_i[7:6])) |=> flags_o[5]);

   assert_exact_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb_i && sec_i == alm_sec_i && min_i == alm_min_i && hr_i == alm_hr_i) |=> flags_o[5]);

   assert_upd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb_i |=> flags_o[4]);

   assert_per_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      per_tick_i |=> flags_o[6]);

   assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[3:0] == 4'h0);

   assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_drive_low_o |-> |(flags_o[6:4] & {en_per_i, en_alm_i, en_upd_i}));

   assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_drive_low_o && !flag_rd_i) |=> |flags_o[6:4]);

   assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd_i && !upd_stb_i && !per_tick_i) |=> (flags_o[6:4] == 3'b000));

   assert_keep_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd_i && per_tick_i) |=> flags_o[6]);
endmodule

bind tod_alarm_irq tod_alarm_irq_chk chk_i (.*);

// File: tb/tod_alarm_irq_tb.sv
module tod_alarm_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sec_i = '0, min_i = '0, hr_i = '0;
   logic [7:0] alm_sec_i = '0, alm_min_i = '0, alm_hr_i = '0;
   logic       upd_stb_i = 1'b0, per_tick_i = 1'b0;
   logic       en_per_i = 1'b0, en_alm_i = 1'b0, en_upd_i = 1'b0;
   logic       flag_rd_i = 1'b0;
   logic [7:0] flags_o;
   logic       irq_drive_low_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tod_alarm_irq dut_i (.*);

   typedef struct packed {
      logic [7:0] s, m, h, as, am, ah;
      logic       exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b1},  // R4 exact
      '{8'h57, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b0},  // R4 sec off
      '{8'h00, 8'h15, 8'h92, 8'h00, 8'h15, 8'h92, 1'b1},  // R4 PM code
      '{8'h10, 8'h20, 8'h07, 8'h10, 8'h20, 8'hC0, 1'b1},  // R3 hourly
      '{8'h10, 8'h21, 8'h07, 8'h10, 8'h20, 8'hC0, 1'b0},  // R3 hourly miss
      '{8'h33, 8'h44, 8'h05, 8'h33, 8'hC5, 8'hFF, 1'b1},  // R3 minutely
      '{8'h34, 8'h44, 8'h05, 8'h33, 8'hC5, 8'hFF, 1'b0},  // R3 minutely miss
      '{8'h09, 8'h59, 8'h23, 8'hC0, 8'hE1, 8'hFF, 1'b1},  // R3 every second
      '{8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h80, 1'b0},  // R2 0x80 no wild
      '{8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h40, 1'b0},  // R2 0x40 no wild
      '{8'hBF, 8'h00, 8'h01, 8'hBF, 8'h00, 8'hFF, 1'b1}   // R2 0xBF exact
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk) upd_stb_i = 1'b1;
      @(negedge clk) upd_stb_i = 1'b0;
   endtask

   task automatic rd_clear();
      @(negedge clk) flag_rd_i = 1'b1;
      @(negedge clk) flag_rd_i = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 flags after reset", flags_o, 8'h00);
      check("R10 irq after reset", {7'd0, irq_drive_low_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk: alarm enabled, expect alarm + update-ended bits
      en_alm_i = 1'b1;
      for (int i = 0; i < NV; i++) begin
         sec_i = VECS[i].s; min_i = VECS[i].m; hr_i = VECS[i].h;
         alm_sec_i = VECS[i].as; alm_min_i = VECS[i].am; alm_hr_i = VECS[i].ah;
         strobe();
         check($sformatf("R2/R3/R4 vec%0d flags", i), flags_o,
               VECS[i].exp ? 8'hB0 : 8'h10);
         check($sformatf("R7 vec%0d irq", i), {7'd0, irq_drive_low_o}, {7'd0, VECS[i].exp});
         rd_clear();
         check($sformatf("R8 vec%0d cleared", i), flags_o, 8'h00);
      end

      // R1: matching time but no strobe -> no alarm
      sec_i = 8'h01; min_i = 8'h02; hr_i = 8'h03;
      alm_sec_i = 8'h01; alm_min_i = 8'h02; alm_hr_i = 8'h03;
      repeat (4) @(negedge clk);
      check("R1 no strobe no alarm", flags_o, 8'h00);

      // R7: flags set with enables off, irq not driven
      en_alm_i = 1'b0;
      strobe();
      check("R7 flags without enable", flags_o, 8'h30);
      check("R7 no irq without enable", {7'd0, irq_drive_low_o}, 8'h00);
      en_upd_i = 1'b1;
      #0.1;
      check("R7 enabling drives irq", flags_o, 8'hB0);

      // R8 level hold
      repeat (5) @(negedge clk);
      check("R8 irq held", {7'd0, irq_drive_low_o}, 8'h01);
      rd_clear();
      check("R8 irq released", {7'd0, irq_drive_low_o}, 8'h00);

      // R5 periodic tick
      @(negedge clk) per_tick_i = 1'b1;
      @(negedge clk) per_tick_i = 1'b0;
      check("R5 periodic flag", flags_o, 8'h40);
      en_per_i = 1'b1;
      #0.1;
      check("R6 summary with periodic", flags_o, 8'hC0);

      // R9: tick in the same cycle as a read survives
      alm_sec_i = 8'h99;
      strobe();
      check("R9 setup", flags_o, 8'hD0);
      @(negedge clk) begin flag_rd_i = 1'b1; per_tick_i = 1'b1; end
      @(negedge clk) begin flag_rd_i = 1'b0; per_tick_i = 1'b0; end
      check("R9 tick kept on read", flags_o, 8'hC0);

      // R9: strobe with alarm hit during read keeps alarm + update flags
      alm_sec_i = 8'h01;
      en_per_i = 1'b0; en_upd_i = 1'b0;
      @(negedge clk) begin flag_rd_i = 1'b1; upd_stb_i = 1'b1; end
      @(negedge clk) begin flag_rd_i = 1'b0; upd_stb_i = 1'b0; end
      check("R9 alarm kept on read", flags_o, 8'h30);
      rd_clear();
      check("R8 final clear", flags_o, 8'h00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule